// File: doc/BRIEF.md
# Survivor Memory Traceback Controller

This block sits behind the add-compare-select stage of a trellis decoder. Each cycle in which the stage delivers a decision vector (one bit per trellis state), the block stores it in an internal dual-port memory. The memory holds two traceback windows. While one window fills through an up-counting write address, the other is read backwards through a down-counting read address, and a traceback state machine walks the trellis from a supplied start state. Each read step yields one decoded bit.

The two counters move in lockstep on accepted vectors. With no vector offered, the controller raises a pause strobe that freezes both counters and the traceback state, so nothing stale is written or read. Reading starts only after the first window is complete. Each time a window completes, the start state presented on that cycle seeds the traceback of that window. Decoded bits leave a window in reverse time order; putting them back in order is left to a later stage.

Top module: `surv_tb_ctrl`

## Requirements
- R1: After reset, wr_addr is 0, rd_addr is TB_LEN-1 (31), valid_out and bit_out are 0, and oe is 0.
- R2: we equals dec_valid and pause equals its inverse. wr_addr advances by one, modulo 2*TB_LEN (64), after each cycle with we high, and holds after each cycle with pause high.
- R3: oe stays low until TB_LEN (32) vectors have been written. From the next accepted vector onward, oe equals dec_valid.
- R4: rd_addr decreases by one, modulo 64, after each cycle with oe high, and holds otherwise. Whenever oe is high, rd_addr and wr_addr lie in different halves of the memory (their top bits differ).
- R5: On a write to an address whose low log2(TB_LEN) bits are all ones, the traceback state is loaded from start_state. The first read of the following window starts from that state.
- R6: On each read step with current state S, the decoded bit is the MSB of S. The next state is S shifted right by one, with bit S of the vector stored at rd_addr entering as the new MSB.
- R7: valid_out is high exactly in the cycle after a cycle with oe high. In that cycle bit_out carries the bit decoded in the read step.
- R8: During a pause, valid_out is low afterwards and bit_out, the traceback state, wr_addr and rd_addr keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_vec | input | NUM_STATES | Decision vector, one bit per state |
| dec_valid | input | 1 | Decision vector present this cycle |
| start_state | input | log2(NUM_STATES) | Traceback start state, sampled when a window completes |
| we | output | 1 | Memory write strobe |
| wr_addr | output | log2(2*TB_LEN) | Write address (up counter) |
| oe | output | 1 | Memory read strobe (traceback step) |
| rd_addr | output | log2(2*TB_LEN) | Read address (down counter) |
| pause | output | 1 | Counter freeze strobe |
| bit_out | output | 1 | Decoded bit |
| valid_out | output | 1 | bit_out is valid this cycle |

## Verification
Writing a new vector and reading an older one happen in the same cycle whenever traceback runs. At a window boundary, the last write of one half also coincides with the final read of the other half and with the reseeding of the traceback state. Long streams of random vectors drive both halves through several wraps. Pauses are placed on and next to the boundary cycle. A bench model predicts the addresses, the strobes and each decoded bit, and the bench compares them in every step. The model shows whether the read came from the half not being written and whether the new start state was taken instead of the step's successor state.

// File: rtl/surv_tb_pkg.sv
package surv_tb_pkg;
   typedef enum logic {
      TB_IDLE = 1'b0,
      TB_RUN  = 1'b1
   } tb_phase_e;
endpackage

// File: rtl/surv_wr_ctr.sv
module surv_wr_ctr #(
   parameter int TB_LEN = 32,
   parameter int ADDR_W = $clog2(2 * TB_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              half_done
);
   localparam int LOW_W = $clog2(TB_LEN);

   // the last slot of either half is the one with all low bits set
   assign half_done = step && (&wr_addr[LOW_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_addr <= '0;
      else if (step)
         wr_addr <= wr_addr + 1'b1;
   end
endmodule

// File: rtl/surv_mem.sv
module surv_mem #(
   parameter int WIDTH  = 4,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [WIDTH-1:0]  rd_data
);
   logic [WIDTH-1:0] rows [DEPTH];

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == ADDR_W'(r)))
            rows[r] <= wr_data;
      end
   end

   assign rd_data = rows[rd_idx];
endmodule

// File: rtl/surv_traceback.sv
module surv_traceback
   import surv_tb_pkg::*;
#(
   parameter int NUM_STATES = 4,
   parameter int TB_LEN     = 32,
   parameter int SW         = $clog2(NUM_STATES),
   parameter int ADDR_W     = $clog2(2 * TB_LEN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  half_done,
   input  logic [SW-1:0]         start_state,
   input  logic [NUM_STATES-1:0] rd_data,
   output logic                  oe,
   output logic [ADDR_W-1:0]     rd_addr,
   output logic                  bit_out,
   output logic                  valid_out
);
   tb_phase_e     phase;
   logic [SW-1:0] cur_state;
   logic [SW-1:0] succ_state;
   logic          dec_bit;

   assign oe      = (phase == TB_RUN) && step;
   assign dec_bit = rd_data[cur_state];

   if (SW == 1) begin : g_succ_one
      assign succ_state = dec_bit;
   end else begin : g_succ_wide
      assign succ_state = {dec_bit, cur_state[SW-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= TB_IDLE;
         cur_state <= '0;
      end else if (half_done) begin
         phase     <= TB_RUN;
         cur_state <= start_state;
      end else if (oe) begin
         cur_state <= succ_state;
      end
   end

   // wrapping decrement moves from the bottom of one half to the top of the other
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_addr <= ADDR_W'(TB_LEN - 1);
      else if (oe)
         rd_addr <= rd_addr - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_out   <= 1'b0;
         valid_out <= 1'b0;
      end else begin
         valid_out <= oe;
         if (oe)
            bit_out <= cur_state[SW-1];
      end
   end
endmodule

// File: rtl/surv_tb_ctrl.sv
module surv_tb_ctrl #(
   parameter int NUM_STATES = 4,
   parameter int TB_LEN     = 32,
   localparam int SW        = $clog2(NUM_STATES),
   localparam int DEPTH     = 2 * TB_LEN,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STATES-1:0] dec_vec,
   input  logic                  dec_valid,
   input  logic [SW-1:0]         start_state,
   output logic                  we,
   output logic [ADDR_W-1:0]     wr_addr,
   output logic                  oe,
   output logic [ADDR_W-1:0]     rd_addr,
   output logic                  pause,
   output logic                  bit_out,
   output logic                  valid_out
);
   if (NUM_STATES < 2 || (1 << SW) != NUM_STATES) begin : g_bad_states
      $error("NUM_STATES must be a power of two of at least 2");
   end
   if (TB_LEN < 2 || (1 << $clog2(TB_LEN)) != TB_LEN) begin : g_bad_len
      $error("TB_LEN must be a power of two of at least 2");
   end

   logic                  half_done;
   logic [NUM_STATES-1:0] rd_data;

   assign we    = dec_valid;
   assign pause = !dec_valid;

   surv_wr_ctr #(.TB_LEN(TB_LEN), .ADDR_W(ADDR_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (we),
      .wr_addr   (wr_addr),
      .half_done (half_done)
   );

   surv_mem #(.WIDTH(NUM_STATES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk     (clk),
      .wr_en   (we),
      .wr_idx  (wr_addr),
      .wr_data (dec_vec),
      .rd_idx  (rd_addr),
      .rd_data (rd_data)
   );

   surv_traceback #(
      .NUM_STATES (NUM_STATES),
      .TB_LEN     (TB_LEN),
      .SW         (SW),
      .ADDR_W     (ADDR_W)
   ) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (we),
      .half_done   (half_done),
      .start_state (start_state),
      .rd_data     (rd_data),
      .oe          (oe),
      .rd_addr     (rd_addr),
      .bit_out     (bit_out),
      .valid_out   (valid_out)
   );
endmodule

// File: rtl/surv_tb_ctrl_chk.sv
module surv_tb_ctrl_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic              pause,
   input logic              oe,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              valid_out,
   input logic              bit_out
);
   // R2
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

   // R8
   pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> $stable(wr_addr) && $stable(rd_addr) && $stable(bit_out) && !valid_out);

   // R4
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |=> rd_addr == ADDR_W'($past(rd_addr) - 1'b1));

   // R4
   half_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> rd_addr[ADDR_W-1] != wr_addr[ADDR_W-1]);

   // R3
   oe_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> we);

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |=> valid_out);

   // R7
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |=> !valid_out);
endmodule

bind surv_tb_ctrl surv_tb_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we        (we),
   .pause     (pause),
   .oe        (oe),
   .wr_addr   (wr_addr),
   .rd_addr   (rd_addr),
   .valid_out (valid_out),
   .bit_out   (bit_out)
);

// File: tb/surv_tb_ctrl_tb.sv
`timescale 1ns/1ps
module surv_tb_ctrl_tb;
   localparam int NS = 4;
   localparam int SWB = 2;
   localparam int TBL = 32;
   localparam int AW = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NS-1:0]  dec_vec = '0;
   logic           dec_valid = 1'b0;
   logic [SWB-1:0] start_state = '0;
   logic           we, oe, pause, bit_out, valid_out;
   logic [AW-1:0]  wr_addr, rd_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   logic [NS-1:0]  m_mem [2*TBL];
   logic [AW-1:0]  m_wr, m_rd;
   logic           m_active;
   logic [SWB-1:0] m_state;
   logic           m_bit;

   always #5 clk = ~clk;

   surv_tb_ctrl #(.NUM_STATES(NS), .TB_LEN(TBL)) u_dut (
      .clk(clk), .rst_n(rst_n), .dec_vec(dec_vec), .dec_valid(dec_valid),
      .start_state(start_state), .we(we), .wr_addr(wr_addr), .oe(oe),
      .rd_addr(rd_addr), .pause(pause), .bit_out(bit_out), .valid_out(valid_out)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_wr = '0; m_rd = AW'(TBL - 1); m_active = 1'b0; m_state = '0; m_bit = 1'b0;
   endtask

   task automatic step(input logic v, input logic [NS-1:0] vec, input logic [SWB-1:0] ss,
                       input string req);
      logic e_oe;
      logic e_bit;
      logic [SWB-1:0] nstate;
      @(negedge clk);
      dec_valid = v; dec_vec = vec; start_state = ss;
      #1;
      e_oe = m_active && v;
      chk(req, "oe", oe, e_oe);
      chk("R2", "we", we, v);
      chk("R2", "pause", pause, !v);
      chk("R2", "wr_addr", wr_addr, m_wr);
      chk("R4", "rd_addr", rd_addr, m_rd);
      e_bit = m_bit;
      nstate = m_state;
      if (e_oe) begin
         e_bit  = m_state[SWB-1];
         nstate = {m_mem[m_rd][m_state], m_state[SWB-1]};
         m_rd   = m_rd - 1'b1;
      end
      if (v) m_mem[m_wr] = vec;
      if (v && (&m_wr[4:0])) begin
         m_state = ss; m_active = 1'b1;
      end else begin
         m_state = nstate;
      end
      if (v) m_wr = m_wr + 1'b1;
      m_bit = e_bit;
      @(posedge clk); #1;
      chk("R7", "valid_out", valid_out, e_oe);
      if (e_oe) chk(req, "bit_out", bit_out, e_bit);
      else      chk("R8", "bit_out hold", bit_out, e_bit);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; dec_valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "wr_addr", wr_addr, 0);
      chk("R1", "rd_addr", rd_addr, TBL - 1);
      chk("R1", "valid_out", valid_out, 0);
      chk("R1", "bit_out", bit_out, 0);
      chk("R1", "oe", oe, 0);
      rst_n = 1'b1;
      model_reset();
   endtask

   // R3: no read before the first window is full, even with gaps
   task automatic t_first_half();
      for (int i = 0; i < TBL; i++) begin
         step(1'b1, NS'($urandom), SWB'($urandom), "R3");
         if (i % 7 == 3) step(1'b0, '0, '0, "R3");
      end
      step(1'b1, NS'($urandom), SWB'($urandom), "R3");
   endtask

   // R6: continuous stream across several wraps
   task automatic t_stream();
      for (int i = 0; i < 3 * 2 * TBL; i++)
         step(1'b1, NS'($urandom), SWB'($urandom), "R6");
   endtask

   // R8: pauses near and on window boundaries
   task automatic t_pause();
      for (int i = 0; i < 2 * 2 * TBL; i++) begin
         logic near;
         near = (m_wr[4:0] >= 5'd30) || (m_wr[4:0] <= 5'd1);
         if (near || ($urandom % 4 == 0)) step(1'b0, NS'($urandom), SWB'($urandom), "R8");
         step(1'b1, NS'($urandom), SWB'($urandom), "R8");
      end
   endtask

   // R5: known decisions, distinct start states per window
   task automatic t_start_state();
      t_reset();
      for (int w = 0; w < 5; w++) begin
         for (int i = 0; i < TBL; i++) begin
            logic [SWB-1:0] ss;
            ss = (i == TBL - 1) ? SWB'(w + 1) : SWB'($urandom);
            step(1'b1, (w % 2 == 0) ? NS'(0) : NS'(4'hF), ss, "R5");
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      t_reset();
      t_first_half();
      t_stream();
      t_pause();
      t_start_state();
      t_pause();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule